// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This unit forms a 32-bit effective address for a complex-addressing load/store or address-compute path. A request names an optional base register, an optional index register with a scale of 1, 2, 4 or 8, and an optional signed displacement of 1, 2 or 4 bytes. The unit adds the present parts, wrapping modulo 2^32. It holds its own file of eight 32-bit general registers, loaded through a write port. Register 4 is the stack pointer and may not act as an index.

A mode bit picks what happens with the sum. In memory mode the unit raises a read request for four consecutive bytes starting at the address. In address-only mode the sum is handed back as a result value and no memory is touched. A request that uses the stack pointer as its index is refused: the fault flag is set and neither a read nor a result is produced.

A small state machine registers the outcome one cycle after the request. Its states are ST_IDLE (no output), ST_MEMRD (read request), ST_ADDR (address result) and ST_FAULT (refused request). From every state, a cycle with `req_valid` low goes to ST_IDLE. A cycle with `req_valid` high goes to ST_FAULT when the index is present and is register 4. Otherwise it goes to ST_ADDR in address-only mode and to ST_MEMRD in memory mode. Back-to-back requests are therefore accepted on every cycle.

Top module: `seaa_unit`

## Requirements
- R1: `out_addr` equals base term + scaled index term + displacement term, added modulo 2^32 with no overflow indication.
- R2: `req_scale` codes 0, 1, 2 and 3 multiply the index value by 1, 2, 4 and 8, which is a left shift by the code.
- R3: `req_disp_size` code 0 gives a zero displacement, code 1 sign-extends `req_disp[7:0]`, code 2 sign-extends `req_disp[15:0]`, and code 3 uses all 32 bits.
- R4: When `req_base_en` is 0 the base term is zero, and when `req_idx_en` is 0 the index term is zero. Any of registers 0 to 7, register 4 included, may serve as the base.
- R5: A request with `req_idx_en`=1 and `req_idx_sel`=4 gives `fault`=1, `rd_req`=0, `res_valid`=0 and `out_addr`=0. When `req_idx_en`=0, `req_idx_sel`=4 causes no fault.
- R6: In address-only mode (`req_addr_only`=1) a non-faulting request gives `res_valid`=1, `rd_req`=0 and `out_addr` holding the address.
- R7: In memory mode (`req_addr_only`=0) a non-faulting request gives `rd_req`=1 and `res_valid`=0. This asks for a 4-byte read starting at `out_addr`.
- R8: The outputs for a request appear one cycle after the cycle in which `req_valid` is high, with `out_valid`=1 for that single cycle. After a cycle without a request, `out_valid`, `rd_req`, `res_valid` and `fault` are 0.
- R9: A register write in the same cycle as a request does not affect that request's address. The next request sees the written value.
- R10: After reset all outputs are 0 and all eight registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_base_en | input | 1 | Base register present |
| req_base_sel | input | 3 | Base register number |
| req_idx_en | input | 1 | Index register present |
| req_idx_sel | input | 3 | Index register number |
| req_scale | input | 2 | Index shift amount (0 to 3) |
| req_disp | input | 32 | Displacement field |
| req_disp_size | input | 2 | Displacement size: 0 none, 1 byte, 2 half, 3 word |
| req_addr_only | input | 1 | 1 = deliver address as result, 0 = memory read |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register number to write |
| wr_data | input | 32 | Register write data |
| out_valid | output | 1 | Outcome pulse for a request |
| rd_req | output | 1 | Request a 4-byte read at out_addr |
| res_valid | output | 1 | out_addr is an address-only result |
| fault | output | 1 | Request refused: stack pointer used as index |
| out_addr | output | 32 | Effective address |

## Verification
A register write and an address request can fall in the same cycle, and both may name the same register. The bench provokes this by driving a write to the base register and a request that reads it on one edge. It then judges the first result against the register's old value and a following request against the new value. A fault and a read request can never both come from one request. A near-exhaustive sweep therefore checks every outcome pulse for exactly one of read, result or fault, and each outcome is compared with an address computed arithmetically.

// File: rtl/seaa_pkg.sv
package seaa_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned NREG   = 8;
    localparam int unsigned SEL_W  = $clog2(NREG);
    localparam int unsigned SCL_W  = 2;
    localparam int unsigned DSZ_W  = 2;
    localparam logic [SEL_W-1:0] SP_REG = SEL_W'(4);

    typedef enum logic [DSZ_W-1:0] {
        DSZ_NONE = 2'd0,
        DSZ_B8   = 2'd1,
        DSZ_B16  = 2'd2,
        DSZ_B32  = 2'd3
    } dsz_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MEMRD = 2'd1,
        ST_ADDR  = 2'd2,
        ST_FAULT = 2'd3
    } st_e;
endpackage

// File: rtl/seaa_regfile.sv
module seaa_regfile
    import seaa_pkg::*;
#(
    parameter int unsigned W = ADDR_W,
    parameter int unsigned N = NREG,
    localparam int unsigned SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] rd_a_sel,
    input  logic [SW-1:0] rd_b_sel,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs_q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && wr_sel == SW'(g))
                regs_q[g] <= wr_data;
        end
    end

    // Reads see the value before any write landing at the coming edge.
    assign rd_a = regs_q[rd_a_sel];
    assign rd_b = regs_q[rd_b_sel];
endmodule

// File: rtl/seaa_addr_calc.sv
module seaa_addr_calc
    import seaa_pkg::*;
#(
    parameter int unsigned W = ADDR_W,
    parameter int unsigned SW = SEL_W
) (
    input  logic              base_en,
    input  logic [W-1:0]      base_val,
    input  logic              idx_en,
    input  logic [SW-1:0]     idx_sel,
    input  logic [W-1:0]      idx_val,
    input  logic [SCL_W-1:0]  scale,
    input  logic [W-1:0]      disp,
    input  logic [DSZ_W-1:0]  disp_size,
    output logic [W-1:0]      ea,
    output logic              bad_idx
);
    logic [W-1:0] base_term;
    logic [W-1:0] idx_term;
    logic [W-1:0] disp_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        idx_term  = idx_en ? (idx_val << scale) : '0;
        unique case (dsz_e'(disp_size))
            DSZ_NONE: disp_term = '0;
            DSZ_B8:   disp_term = {{(W-8){disp[7]}}, disp[7:0]};
            DSZ_B16:  disp_term = {{(W-16){disp[15]}}, disp[15:0]};
            DSZ_B32:  disp_term = disp;
            default:  disp_term = '0;
        endcase
        ea      = base_term + idx_term + disp_term;
        bad_idx = idx_en && (idx_sel == SP_REG);
    end
endmodule

// File: rtl/seaa_ctrl.sv
module seaa_ctrl
    import seaa_pkg::*;
#(
    parameter int unsigned W = ADDR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         addr_only,
    input  logic         bad_idx,
    input  logic [W-1:0] ea,
    output logic         out_valid,
    output logic         rd_req,
    output logic         res_valid,
    output logic         fault,
    output logic [W-1:0] out_addr
);
    st_e          state_q, state_d;
    logic [W-1:0] addr_q;

    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (bad_idx)
            state_d = ST_FAULT;
        else if (addr_only)
            state_d = ST_ADDR;
        else
            state_d = ST_MEMRD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= (req_valid && !bad_idx) ? ea : '0;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        rd_req    = 1'b0;
        res_valid = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_MEMRD: begin out_valid = 1'b1; rd_req    = 1'b1; end
            ST_ADDR:  begin out_valid = 1'b1; res_valid = 1'b1; end
            ST_FAULT: begin out_valid = 1'b1; fault     = 1'b1; end
            default:  ;
        endcase
        out_addr = addr_q;
    end
endmodule

// File: rtl/seaa_unit.sv
module seaa_unit
    import seaa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_base_en,
    input  logic [2:0]  req_base_sel,
    input  logic        req_idx_en,
    input  logic [2:0]  req_idx_sel,
    input  logic [1:0]  req_scale,
    input  logic [31:0] req_disp,
    input  logic [1:0]  req_disp_size,
    input  logic        req_addr_only,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        out_valid,
    output logic        rd_req,
    output logic        res_valid,
    output logic        fault,
    output logic [31:0] out_addr
);
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] idx_val;
    logic [ADDR_W-1:0] ea;
    logic              bad_idx;

    seaa_regfile #(.W(ADDR_W), .N(NREG)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_a_sel (req_base_sel),
        .rd_b_sel (req_idx_sel),
        .rd_a     (base_val),
        .rd_b     (idx_val)
    );

    seaa_addr_calc #(.W(ADDR_W), .SW(SEL_W)) calc_i (
        .base_en   (req_base_en),
        .base_val  (base_val),
        .idx_en    (req_idx_en),
        .idx_sel   (req_idx_sel),
        .idx_val   (idx_val),
        .scale     (req_scale),
        .disp      (req_disp),
        .disp_size (req_disp_size),
        .ea        (ea),
        .bad_idx   (bad_idx)
    );

    seaa_ctrl #(.W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .addr_only (req_addr_only),
        .bad_idx   (bad_idx),
        .ea        (ea),
        .out_valid (out_valid),
        .rd_req    (rd_req),
        .res_valid (res_valid),
        .fault     (fault),
        .out_addr  (out_addr)
    );
endmodule

// File: rtl/seaa_unit_chk.sv
module seaa_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_idx_en,
    input logic [2:0]  req_idx_sel,
    input logic        req_addr_only,
    input logic        out_valid,
    input logic        rd_req,
    input logic        res_valid,
    input logic        fault,
    input logic [31:0] out_addr
);
    a_r5_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rd_req && !res_valid && out_addr == 32'd0));

    a_r5_sp_index_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx_en && req_idx_sel == 3'd4) |=> fault);

    a_r6_addr_only_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr_only) |=> !rd_req);

    a_r7_mem_mode_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr_only) |=> !res_valid);

    a_r8_pulse_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r8_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !rd_req && !res_valid && !fault));

    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({rd_req, res_valid, fault}) == 1));
endmodule

bind seaa_unit seaa_unit_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_idx_en    (req_idx_en),
    .req_idx_sel   (req_idx_sel),
    .req_addr_only (req_addr_only),
    .out_valid     (out_valid),
    .rd_req        (rd_req),
    .res_valid     (res_valid),
    .fault         (fault),
    .out_addr      (out_addr)
);

// File: tb/seaa_unit_tb_top.sv
module seaa_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_base_en = 1'b0;
    logic [2:0]  req_base_sel = '0;
    logic        req_idx_en = 1'b0;
    logic [2:0]  req_idx_sel = '0;
    logic [1:0]  req_scale = '0;
    logic [31:0] req_disp = '0;
    logic [1:0]  req_disp_size = '0;
    logic        req_addr_only = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        out_valid, rd_req, res_valid, fault;
    logic [31:0] out_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] bm [8];

    always #5 clk = ~clk;

    seaa_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_base_en(req_base_en), .req_base_sel(req_base_sel),
        .req_idx_en(req_idx_en), .req_idx_sel(req_idx_sel),
        .req_scale(req_scale), .req_disp(req_disp),
        .req_disp_size(req_disp_size), .req_addr_only(req_addr_only),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_valid(out_valid), .rd_req(rd_req), .res_valid(res_valid),
        .fault(fault), .out_addr(out_addr)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ea(input logic be, input logic [2:0] b,
            input logic ie, input logic [2:0] i, input logic [1:0] s,
            input logic [31:0] d, input logic [1:0] dsz);
        logic [31:0] dt;
        case (dsz)
            2'd0: dt = 32'd0;
            2'd1: dt = {{24{d[7]}}, d[7:0]};
            2'd2: dt = {{16{d[15]}}, d[15:0]};
            default: dt = d;
        endcase
        return (be ? bm[b] : 32'd0) + (ie ? bm[i] * (32'd1 << s) : 32'd0) + dt;
    endfunction

    // Drives one request at a falling edge, samples the outcome at the next one.
    task automatic do_req(input string tag, input logic be, input logic [2:0] b,
            input logic ie, input logic [2:0] i, input logic [1:0] s,
            input logic [31:0] d, input logic [1:0] dsz, input logic ao);
        logic f;
        logic [31:0] e;
        f = ie && (i == 3'd4);
        e = f ? 32'd0 : model_ea(be, b, ie, i, s, d, dsz);
        req_valid = 1'b1; req_base_en = be; req_base_sel = b; req_idx_en = ie;
        req_idx_sel = i; req_scale = s; req_disp = d; req_disp_size = dsz;
        req_addr_only = ao;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {out_valid, rd_req, res_valid, fault, out_addr},
              {1'b1, !f && !ao, !f && ao, f, e});
    endtask

    task automatic write_reg(input logic [2:0] r, input logic [31:0] v);
        wr_en = 1'b1; wr_sel = r; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        bm[r] = v;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) bm[k] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state of outputs and registers
        check("R10 outputs after reset", {out_valid, rd_req, res_valid, fault, out_addr}, 36'd0);
        do_req("R10 registers zero", 1'b1, 3'd3, 1'b1, 3'd6, 2'd3, 32'd0, 2'd0, 1'b1);
        // R8: no request, no pulse
        @(negedge clk);
        check("R8 quiet cycle", {out_valid, rd_req, res_valid, fault, out_addr}, 36'd0);

        for (int k = 0; k < 8; k++) write_reg(3'(k), 32'hF000_0000 + 32'(k) * 32'h1357_9BDF);

        // R1/R2/R3/R4/R5/R6/R7 sweep
        for (int b = 0; b < 8; b++)
            for (int i = 0; i < 8; i++)
                for (int s = 0; s < 4; s++)
                    for (int dz = 0; dz < 4; dz++)
                        for (int c = 0; c < 4; c++)
                            for (int m = 0; m < 2; m++) begin
                                logic [31:0] d;
                                d = 32'h8765_43A9 ^ (32'(b) * 32'h0101_0101) ^ (32'(s) << 14);
                                do_req((c[1] && i == 4) ? "R5 stack index" :
                                       (m == 1 ? "R6 address only R1 R2 R3 R4" : "R7 memory R1 R2 R3 R4"),
                                       c[0], 3'(b), c[1], 3'(i), 2'(s), d, 2'(dz), m[0]);
                            end

        // R1: wrap past 2^32
        write_reg(3'd1, 32'hFFFF_FFF0);
        write_reg(3'd2, 32'h8000_0000);
        do_req("R1 wrap", 1'b1, 3'd1, 1'b1, 3'd2, 2'd1, 32'h0000_0020, 2'd3, 1'b1);
        // R3: negative byte and half displacements
        do_req("R3 byte sext", 1'b1, 3'd1, 1'b0, 3'd0, 2'd0, 32'h0000_0080, 2'd1, 1'b0);
        do_req("R3 half sext", 1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 32'h1234_8000, 2'd2, 1'b0);
        // R9: write and request on the same edge
        req_valid = 1'b1; req_base_en = 1'b1; req_base_sel = 3'd5; req_idx_en = 1'b0;
        req_idx_sel = 3'd0; req_scale = 2'd0; req_disp = 32'd0; req_disp_size = 2'd0;
        req_addr_only = 1'b1;
        wr_en = 1'b1; wr_sel = 3'd5; wr_data = 32'hCAFE_0005;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        check("R9 old value used", {out_valid, res_valid, out_addr}, {1'b1, 1'b1, bm[5]});
        bm[5] = 32'hCAFE_0005;
        do_req("R9 new value next", 1'b1, 3'd5, 1'b0, 3'd0, 2'd0, 32'd0, 2'd0, 1'b1);
        // R8: back-to-back requests then idle
        do_req("R8 back to back a", 1'b0, 3'd0, 1'b1, 3'd7, 2'd2, 32'h10, 2'd3, 1'b0);
        do_req("R8 back to back b", 1'b1, 3'd4, 1'b0, 3'd4, 2'd0, 32'h7F, 2'd1, 1'b1);
        @(negedge clk);
        check("R8 idle after burst", {out_valid, rd_req, res_valid, fault}, 36'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule